// File: doc/BRIEF.md
# Mailbox Memory Loader with Running CRC

This block is a register-mapped mailbox through which a management host, working 16 bits at a time, fills an embedded processor's memory with 32-bit words. The host writes a start address once per contiguous segment. For each word it writes the two data halves and then issues a write command. The block drives a single-cycle write on a 32-bit memory port and then advances its internal address by four bytes. At the same time it feeds the four bytes of the word, most significant first, through a CRC-16 accumulator. After the last word the host reads the accumulator back and compares it with the value it computed on its own side.

A second register holds the processor's stall and reset controls. The firmware bring-up sequence is as follows. Stall the processor with the override set, load memory, pulse reset while the processor is stalled, then drop reset and stall and keep the override. The reset output is stretched by a cycle counter. A host that clears the reset bit too early still produces a reset pulse of the minimum length.

Top module: `mbox_loader`

## Requirements
- R1: After reset every mailbox register reads zero, `mem_we_o`, `cpu_reset_o` and `cpu_stall_o` are low, and the CRC reads 0x0000. The register offsets are: mailbox control at MBOX_BASE+0, CRC at +1, address high at +2, address low at +3, data high at +4, data low at +5, and processor control at CPU_CTL_ADDR. Every other offset reads 0x0000.
- R2: In the mailbox control register, bit 15 is execute, bit 14 is write, bit 12 clears the CRC, and bit 8 is a read-only busy flag. All other bits read zero.
- R3: A control write with bit 12 set, accepted while the block is idle, clears the CRC accumulator to 0x0000.
- R4: Address bits [1:0] are always zero. The address low register reads them back as zero, and every memory write uses a word-aligned address.
- R5: A control write with bits 15 and 14 set, accepted while the block is idle, pulses `mem_we_o` for exactly one cycle, starting one cycle after the command. During that pulse the port carries the current address and the data {data high, data low}. The current address then advances by 4, so consecutive words land at consecutive word addresses without the address being rewritten.
- R6: Each written word updates the CRC over its four bytes, most significant byte first. The CRC uses polynomial 0x1021, a starting value of zero after a clear, no reflection and no final XOR. One byte is processed per cycle.
- R7: Busy reads 1 for the four cycles of a CRC update that follows an accepted write command. While busy is set, any mailbox control write is ignored: no memory write, no CRC clear, no new command.
- R8: In the processor control register, bit 15 is reset, bit 6 is stall override and bit 0 is stall. `cpu_stall_o` is high exactly when both override and stall are set. The register reads back its three stored bits.
- R9: Setting the reset bit raises `cpu_reset_o` at once and holds it for at least RESET_HOLD_CYCLES cycles, even if the bit is cleared sooner. If the bit stays set longer than that, the output follows the bit and falls one cycle after the bit is cleared.
- R10: A control write with execute set and write clear causes no memory write. It leaves busy, the address and the CRC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 16 | Host register offset for reads and writes |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for the offset on `reg_addr`, combinational |
| mem_we_o | output | 1 | Memory write pulse |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write word |
| cpu_reset_o | output | 1 | Processor reset, stretched to the minimum hold |
| cpu_stall_o | output | 1 | Processor stall |

## Verification
Two segments are loaded with words chosen to separate the byte order from its reverse: distinct bytes, all zeros, all ones and alternating bits. A model CRC that matches the accumulator only when the bytes go in most significant first confirms both the polynomial and the order. Back-to-back commands issued during busy, a clear issued during busy, and an execute without the write bit are distinguished by the number of memory writes the scoreboard sees and by the CRC and address read back afterwards. The reset output is tested twice: once with the bit cleared early, to check the stretched pulse, and once with the bit held past the minimum, to check that the output follows the bit.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned CRC_W     = 16;
    localparam int unsigned BYTE_W    = 8;

    // mailbox control register fields
    localparam int unsigned CTL_EXEC  = 15;
    localparam int unsigned CTL_WRITE = 14;
    localparam int unsigned CTL_CLR   = 12;
    localparam int unsigned CTL_BUSY  = 8;

    // processor control register fields
    localparam int unsigned CPU_RST   = 15;
    localparam int unsigned CPU_OVR   = 6;
    localparam int unsigned CPU_STALL = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTL,
        SEL_CRC,
        SEL_AHI,
        SEL_ALO,
        SEL_DHI,
        SEL_DLO,
        SEL_CPU
    } reg_sel_e;

    // one byte through a non-reflected CRC-16, most significant bit first
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] crc_in,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] c;
        c = crc_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (c[CRC_W-1] ^ b[i]) c = {c[CRC_W-2:0], 1'b0} ^ poly;
            else                   c = {c[CRC_W-2:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/mbox_crc.sv
module mbox_crc
    import mbox_pkg::*;
#(
    parameter int unsigned   WORD_W = 32,
    parameter logic [15:0]   POLY   = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [CRC_W-1:0]  crc_o,
    output logic              busy_o
);

    localparam int unsigned BYTES = WORD_W / BYTE_W;
    localparam int unsigned CNT_W = $clog2(BYTES + 1);

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  left;
    } crc_st_t;

    crc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) begin
            st_d.crc  = crc_byte(st_q.crc, st_q.word[WORD_W-1 -: BYTE_W], POLY);
            st_d.word = st_q.word << BYTE_W;
            st_d.left = st_q.left - CNT_W'(1);
        end
        if (clr_i) begin
            st_d.crc = '0;
        end
        if (start_i) begin
            st_d.word = word_i;
            st_d.left = CNT_W'(BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign crc_o  = st_q.crc;
    assign busy_o = (st_q.left != '0);

endmodule

// File: rtl/mbox_seq.sv
module mbox_seq #(
    parameter int unsigned REG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ahi_i,
    input  logic               wr_alo_i,
    input  logic               wr_dhi_i,
    input  logic               wr_dlo_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               go_i,
    output logic [2*REG_W-1:0] addr_o,
    output logic [2*REG_W-1:0] data_o,
    output logic               mem_we_o,
    output logic [2*REG_W-1:0] mem_addr_o,
    output logic [2*REG_W-1:0] mem_wdata_o
);

    localparam int unsigned WORD_W = 2 * REG_W;
    localparam int unsigned STEP   = WORD_W / 8;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              we;
        logic [WORD_W-1:0] maddr;
        logic [WORD_W-1:0] mdata;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (wr_ahi_i) st_d.addr[WORD_W-1:REG_W] = wdata_i;
        if (wr_alo_i) st_d.addr[REG_W-1:0]      = {wdata_i[REG_W-1:2], 2'b00};
        if (wr_dhi_i) st_d.data[WORD_W-1:REG_W] = wdata_i;
        if (wr_dlo_i) st_d.data[REG_W-1:0]      = wdata_i;
        if (go_i) begin
            st_d.we    = 1'b1;
            st_d.maddr = st_q.addr;
            st_d.mdata = st_q.data;
            st_d.addr  = st_q.addr + WORD_W'(STEP);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o      = st_q.addr;
    assign data_o      = st_q.data;
    assign mem_we_o    = st_q.we;
    assign mem_addr_o  = st_q.maddr;
    assign mem_wdata_o = st_q.mdata;

endmodule

// File: rtl/mbox_cpu_ctl.sv
module mbox_cpu_ctl #(
    parameter int unsigned HOLD_CYCLES = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic rst_req_i,
    input  logic ovr_i,
    input  logic stall_i,
    output logic rst_bit_o,
    output logic ovr_o,
    output logic stall_o,
    output logic cpu_reset_o,
    output logic cpu_stall_o
);

    localparam int unsigned HOLD_W = $clog2(HOLD_CYCLES + 1);

    typedef struct packed {
        logic              rst_bit;
        logic              ovr;
        logic              stall;
        logic [HOLD_W-1:0] cnt;
    } cpu_st_t;

    cpu_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - HOLD_W'(1);
        if (wr_i) begin
            st_d.rst_bit = rst_req_i;
            st_d.ovr     = ovr_i;
            st_d.stall   = stall_i;
            if (rst_req_i && !st_q.rst_bit) st_d.cnt = HOLD_W'(HOLD_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_bit_o   = st_q.rst_bit;
    assign ovr_o       = st_q.ovr;
    assign stall_o     = st_q.stall;
    assign cpu_reset_o = st_q.rst_bit | (st_q.cnt != '0);
    assign cpu_stall_o = st_q.ovr & st_q.stall;

endmodule

// File: rtl/mbox_loader.sv
module mbox_loader
    import mbox_pkg::*;
#(
    parameter int unsigned REG_W             = 16,
    parameter logic [15:0] MBOX_BASE         = 16'h0200,
    parameter logic [15:0] CPU_CTL_ADDR      = 16'hC001,
    parameter logic [15:0] CRC_POLY          = 16'h1021,
    parameter int unsigned RESET_HOLD_CYCLES = 12500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [15:0]        reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               mem_we_o,
    output logic [2*REG_W-1:0] mem_addr_o,
    output logic [2*REG_W-1:0] mem_wdata_o,
    output logic               cpu_reset_o,
    output logic               cpu_stall_o
);

    localparam int unsigned WORD_W = 2 * REG_W;

    reg_sel_e          sel;
    logic              busy;
    logic              ctl_wr;
    logic              accept;
    logic              go;
    logic              crc_clr;
    logic [CRC_W-1:0]  crc_val;
    logic [WORD_W-1:0] cur_addr;
    logic [WORD_W-1:0] cur_data;
    logic              cpu_rst_bit;
    logic              cpu_ovr;
    logic              cpu_stall_bit;

    always_comb begin
        sel = SEL_NONE;
        if      (reg_addr == MBOX_BASE)              sel = SEL_CTL;
        else if (reg_addr == MBOX_BASE + 16'd1)      sel = SEL_CRC;
        else if (reg_addr == MBOX_BASE + 16'd2)      sel = SEL_AHI;
        else if (reg_addr == MBOX_BASE + 16'd3)      sel = SEL_ALO;
        else if (reg_addr == MBOX_BASE + 16'd4)      sel = SEL_DHI;
        else if (reg_addr == MBOX_BASE + 16'd5)      sel = SEL_DLO;
        else if (reg_addr == CPU_CTL_ADDR)           sel = SEL_CPU;
    end

    assign ctl_wr  = reg_wr && (sel == SEL_CTL);
    assign accept  = ctl_wr && !busy;
    assign go      = accept && reg_wdata[CTL_EXEC] && reg_wdata[CTL_WRITE];
    assign crc_clr = accept && reg_wdata[CTL_CLR];

    mbox_seq #(.REG_W(REG_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ahi_i   (reg_wr && (sel == SEL_AHI)),
        .wr_alo_i   (reg_wr && (sel == SEL_ALO)),
        .wr_dhi_i   (reg_wr && (sel == SEL_DHI)),
        .wr_dlo_i   (reg_wr && (sel == SEL_DLO)),
        .wdata_i    (reg_wdata),
        .go_i       (go),
        .addr_o     (cur_addr),
        .data_o     (cur_data),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );

    mbox_crc #(.WORD_W(WORD_W), .POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (crc_clr),
        .start_i(go),
        .word_i (cur_data),
        .crc_o  (crc_val),
        .busy_o (busy)
    );

    mbox_cpu_ctl #(.HOLD_CYCLES(RESET_HOLD_CYCLES)) u_cpu (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr && (sel == SEL_CPU)),
        .rst_req_i  (reg_wdata[CPU_RST]),
        .ovr_i      (reg_wdata[CPU_OVR]),
        .stall_i    (reg_wdata[CPU_STALL]),
        .rst_bit_o  (cpu_rst_bit),
        .ovr_o      (cpu_ovr),
        .stall_o    (cpu_stall_bit),
        .cpu_reset_o(cpu_reset_o),
        .cpu_stall_o(cpu_stall_o)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTL: reg_rdata[CTL_BUSY] = busy;
            SEL_CRC: reg_rdata = REG_W'(crc_val);
            SEL_AHI: reg_rdata = cur_addr[WORD_W-1:REG_W];
            SEL_ALO: reg_rdata = cur_addr[REG_W-1:0];
            SEL_DHI: reg_rdata = cur_data[WORD_W-1:REG_W];
            SEL_DLO: reg_rdata = cur_data[REG_W-1:0];
            SEL_CPU: begin
                reg_rdata[CPU_RST]   = cpu_rst_bit;
                reg_rdata[CPU_OVR]   = cpu_ovr;
                reg_rdata[CPU_STALL] = cpu_stall_bit;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbox_loader_checker.sv
module mbox_loader_checker #(
    parameter int unsigned HOLD = 12500
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        busy,
    input logic        ctl_wr,
    input logic        cmd_exec,
    input logic        cmd_write,
    input logic        cmd_clr,
    input logic [15:0] crc,
    input logic        cpu_reset
);

    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= '0;
        else if (cpu_reset) run_q <= (run_q == 32'hFFFF_FFFF) ? run_q : run_q + 32'd1;
        else                run_q <= '0;
    end

    // R4: memory addresses are word aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    // R5: one-cycle write pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: memory write happens inside the busy window
    a_r7_busy_covers_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: command while busy produces no write
    a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctl_wr && cmd_exec && cmd_write) |=> !mem_we);

    // R3: idle clear zeroes the accumulator
    a_r3_crc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ctl_wr && cmd_clr) |=> (crc == 16'h0000));

    // R9: reset pulse never shorter than the hold time
    a_r9_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_reset) |-> (run_q >= HOLD));

endmodule

bind mbox_loader mbox_loader_checker #(.HOLD(RESET_HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we_o),
    .mem_addr (mem_addr_o),
    .busy     (busy),
    .ctl_wr   (ctl_wr),
    .cmd_exec (reg_wdata[15]),
    .cmd_write(reg_wdata[14]),
    .cmd_clr  (reg_wdata[12]),
    .crc      (crc_val),
    .cpu_reset(cpu_reset_o)
);

// File: tb/mbox_loader_bench.sv
module mbox_loader_bench;

    localparam int unsigned HOLD = 50;
    localparam logic [15:0] BASE = 16'h0200;
    localparam logic [15:0] CPUA = 16'hC001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_we_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        cpu_reset_o;
    logic        cpu_stall_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_q[$];
    logic [15:0] crc_m = '0;
    logic [31:0] addr_m = '0;

    always #4 clk = ~clk;

    mbox_loader #(.RESET_HOLD_CYCLES(HOLD)) u_mbox_loader (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .cpu_reset_o(cpu_reset_o), .cpu_stall_o(cpu_stall_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_word(input logic [15:0] c0, input logic [31:0] w);
        logic [15:0] c;
        c = c0;
        for (int k = 31; k >= 0; k--) begin
            if (c[15] ^ w[k]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int n = 0; n < 20; n++) begin
            reg_read(BASE, v);
            if (!v[8]) break;
        end
    endtask

    // driver: push the expected write, then command it
    task automatic load_word(input logic [31:0] w);
        logic [15:0] v;
        reg_write(BASE + 16'd4, w[31:16]);
        reg_write(BASE + 16'd5, w[15:0]);
        exp_q.push_back({addr_m, w});
        crc_m  = crc_word(crc_m, w);
        addr_m = addr_m + 32'd4;
        reg_write(BASE, 16'hC000);
        reg_read(BASE, v);
        chk("R7 busy after command", 64'(v), 64'h0100);
        wait_idle();
    endtask

    // monitor: every memory write must match the scoreboard head (R5)
    always @(negedge clk) begin
        if (rst_n && mem_we_o) begin
            if (exp_q.size() == 0) begin
                chk("R5/R7 unexpected memory write", {mem_addr_o, mem_wdata_o}, 64'h0);
            end else begin
                chk("R5 memory write", {mem_addr_o, mem_wdata_o}, exp_q.pop_front());
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        int hi;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mem_we reset", 64'(mem_we_o), 64'h0);
        chk("R1 cpu_reset reset", 64'(cpu_reset_o), 64'h0);
        chk("R1 cpu_stall reset", 64'(cpu_stall_o), 64'h0);
        reg_read(BASE, v);          chk("R1 control reset", 64'(v), 64'h0);
        reg_read(BASE + 16'd1, v);  chk("R1 crc reset", 64'(v), 64'h0);
        reg_read(CPUA, v);          chk("R1 cpu ctl reset", 64'(v), 64'h0);

        // R1/R4 address and data registers
        reg_write(BASE + 16'd2, 16'h3FFE);
        reg_write(BASE + 16'd3, 16'h0003);
        reg_read(BASE + 16'd2, v);  chk("R1 addr hi readback", 64'(v), 64'h3FFE);
        reg_read(BASE + 16'd3, v);  chk("R4 addr low bits forced zero", 64'(v), 64'h0);
        reg_write(BASE + 16'd4, 16'hA5A5);
        reg_read(BASE + 16'd4, v);  chk("R1 data hi readback", 64'(v), 64'hA5A5);
        reg_read(BASE + 16'd6, v);  chk("R1 unmapped offset", 64'(v), 64'h0);
        addr_m = 32'h3FFE_0000;

        // R8 stall the processor with override
        reg_write(CPUA, 16'h0041);
        chk("R8 stall asserted", 64'(cpu_stall_o), 64'h1);
        reg_read(CPUA, v);          chk("R8 cpu ctl readback", 64'(v), 64'h0041);

        // segment 1: R2/R3/R6
        reg_write(BASE, 16'h1000);
        crc_m = '0;
        load_word(32'h0123_4567);
        load_word(32'hDEAD_BEEF);
        load_word(32'h0000_0000);
        load_word(32'hFFFF_FFFF);
        reg_read(BASE + 16'd1, v);  chk("R6 crc segment 1", 64'(v), 64'(crc_m));
        reg_read(BASE + 16'd3, v);  chk("R5 address advanced", 64'(v), 64'h0010);
        reg_read(BASE + 16'd2, v);  chk("R5 address high kept", 64'(v), 64'h3FFE);

        // R3 clear
        reg_write(BASE, 16'h1000);
        reg_read(BASE + 16'd1, v);  chk("R3 crc cleared", 64'(v), 64'h0);

        // segment 2
        reg_write(BASE + 16'd2, 16'h4000);
        reg_write(BASE + 16'd3, 16'h0000);
        addr_m = 32'h4000_0000;
        crc_m  = '0;
        load_word(32'hAAAA_5555);
        load_word(32'h1122_3344);
        reg_read(BASE + 16'd1, v);  chk("R6 crc segment 2", 64'(v), 64'(crc_m));

        // R7 commands while busy are ignored
        reg_write(BASE + 16'd4, 16'h8001);
        reg_write(BASE + 16'd5, 16'h0203);
        exp_q.push_back({addr_m, 32'h8001_0203});
        crc_m  = crc_word(crc_m, 32'h8001_0203);
        addr_m = addr_m + 32'd4;
        reg_write(BASE, 16'hC000);
        reg_write(BASE, 16'hD000);
        wait_idle();
        reg_read(BASE + 16'd1, v);  chk("R7 crc not cleared while busy", 64'(v), 64'(crc_m));
        reg_read(BASE + 16'd3, v);  chk("R7 single address step", 64'(v), 64'(addr_m[15:0]));

        // R10 execute without write
        reg_write(BASE, 16'h8000);
        reg_read(BASE, v);          chk("R10 no busy", 64'(v), 64'h0);
        reg_read(BASE + 16'd3, v);  chk("R10 address unchanged", 64'(v), 64'(addr_m[15:0]));
        reg_read(BASE + 16'd1, v);  chk("R10 crc unchanged", 64'(v), 64'(crc_m));
        chk("R5 scoreboard drained", 64'(exp_q.size()), 64'h0);

        // R9 short reset request is stretched
        reg_write(CPUA, 16'h8041);
        chk("R9 reset rises", 64'(cpu_reset_o), 64'h1);
        reg_write(CPUA, 16'h0041);
        hi = 2;
        for (int n = 0; n < 4 * HOLD && cpu_reset_o; n++) begin
            hi++;
            @(negedge clk);
        end
        chk("R9 stretched reset length", 64'(hi), 64'(HOLD));

        // R9 long reset follows the bit
        reg_write(CPUA, 16'h8041);
        repeat (2 * HOLD) @(negedge clk);
        chk("R9 reset held by bit", 64'(cpu_reset_o), 64'h1);
        reg_write(CPUA, 16'h0041);
        chk("R9 reset released", 64'(cpu_reset_o), 64'h0);
        chk("R8 stall during reset release", 64'(cpu_stall_o), 64'h1);

        // R8 release with override kept
        reg_write(CPUA, 16'h0040);
        chk("R8 stall cleared", 64'(cpu_stall_o), 64'h0);
        reg_read(CPUA, v);          chk("R8 override kept", 64'(v), 64'h0040);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule